// File: doc/BRIEF.md
# Accumulator ALU with Packed-BCD Correction

This block is the purely combinational arithmetic and logic unit of an 8-bit accumulator processor. A sequencer presents a register value, a memory operand, the current carry, the decimal-mode flag and a 4-bit operation code. In the same cycle the unit returns the result byte, new values for the sign (N), overflow (V), zero (Z) and carry (C) flags, and one write enable per flag. The enables tell the status register which flags the operation is allowed to change.

Add and subtract run through one shared adder. Subtraction inverts the operand and feeds it into that same path. When decimal mode is set, a per-nibble correction turns the binary sum into a packed-BCD sum. The sign, zero and overflow flags still come from the uncorrected binary sum, while the carry comes from the corrected one. The other operations are compare, three bitwise logic operations, a bit test that loads the operand's two top bits into N and V, and left and right shifts and rotates through the carry.

The register file, instruction sequencing and memory access belong to the surrounding processor and are not part of this unit.

Top module: `acc_alu`

## Requirements
- R1: ADD (op 0) with decimal mode clear gives {C, result} = A + M + Cin. V is set when A and M have the same sign bit and the result's sign bit differs. N is result bit 7 and Z is set when the result is zero. All four flag enables are high.
- R2: SUB (op 1) with decimal mode clear gives result = A - M - (1 - Cin) modulo 256. C is set when no borrow occurs (A >= M + (1 - Cin)). V is computed as in R1 with the operand inverted. N and Z come from the result. All four enables are high.
- R3: ADD with decimal mode set forms the binary sum S = A + M + Cin and takes N, Z and V from S exactly as in R1. It then adds 6 to each nibble whose bit position 4k+4 in ((S + 0x66) xor A xor M) is set. C is set when the corrected sum exceeds 0xFF, and the result is its low byte. For valid BCD inputs every result nibble is at most 9.
- R4: SUB with decimal mode set first inverts M and subtracts 0x66 from it modulo 256 (giving M'). It then follows R3 with M' in place of M.
- R5: CMP (op 2) sets C when A >= M (unsigned) and takes N and Z from the byte A - M, which is also the result. V is not written.
- R6: AND (op 3), OR (op 4) and XOR (op 5) return the bitwise function of A and M. N and Z follow the result, and only those two flags are written.
- R7: BIT (op 6) returns A AND M, sets Z when that value is zero, and copies M bit 7 into N and M bit 6 into V. C is not written.
- R8: SHL (op 7) shifts A left, putting 0 into bit 0 and old bit 7 into C. SHR (op 8) shifts A right, putting 0 into bit 7 and old bit 0 into C. N, Z and C are written.
- R9: ROL (op 9) and ROR (op 10) behave like R8 except that Cin enters bit 0 (left) or bit 7 (right).
- R10: A flag value output is 0 whenever its write enable is low. Codes 11 to 15 return result 0 and write no flag.
- R11: The decimal flag has no effect on any operation other than ADD and SUB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1 to R10) |
| reg_a | input | 8 | Accumulator or index register value |
| opnd_m | input | 8 | Memory or immediate operand |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Current decimal-mode flag |
| result | output | 8 | Result byte |
| flag_n | output | 1 | New sign flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| we_n | output | 1 | Sign flag write enable |
| we_v | output | 1 | Overflow flag write enable |
| we_z | output | 1 | Zero flag write enable |
| we_c | output | 1 | Carry flag write enable |

## Verification
Every output depends combinationally on the current inputs, so each result is due zero cycles after its stimulus, within the same clock period. The driver applies a vector just after a rising edge and queues the expected outputs at the same moment. The monitor takes that item from the queue at the following falling edge, so every comparison sees settled outputs of the vector it belongs to. The sweep covers every accumulator value with a spread of operands, both carries, both modes and all sixteen codes, and then adds directed decimal corner cases.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_fn_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  input  logic          sub_i,
  input  logic          dec_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          v_o,
  output logic          n_o,
  output logic          z_o
);
  localparam int unsigned NIB = DW / 4;
  localparam int unsigned SW  = DW + 2;
  localparam logic [DW-1:0] BCD_BIAS = {NIB{4'h6}};

  logic [DW-1:0] m_eff;
  logic [SW-1:0] bin_sum;
  logic [SW-1:0] probe;
  logic [DW-1:0] corr;
  logic [SW-1:0] fixed_sum;

  always_comb begin
    m_eff = sub_i ? ~m_i : m_i;
    if (sub_i && dec_i) begin
      m_eff = m_eff - BCD_BIAS;
    end
  end

  assign bin_sum = {2'b00, a_i} + {2'b00, m_eff} + {{(SW-1){1'b0}}, cin_i};
  assign probe   = (bin_sum + {2'b00, BCD_BIAS}) ^ {2'b00, a_i} ^ {2'b00, m_eff};

  for (genvar k = 0; k < NIB; k++) begin : g_nib_fix
    assign corr[4*k +: 4] = (dec_i && probe[4*k+4]) ? 4'h6 : 4'h0;
  end

  assign fixed_sum = bin_sum + {2'b00, corr};

  assign sum_o = fixed_sum[DW-1:0];
  assign c_o   = |fixed_sum[SW-1:DW];
  assign n_o   = bin_sum[DW-1];
  assign z_o   = (bin_sum[DW-1:0] == '0);
  assign v_o   = (bin_sum[DW-1] ^ a_i[DW-1]) & (bin_sum[DW-1] ^ m_eff[DW-1]);

  logic [DW:0] ref_add;
  logic [DW:0] ref_sub_rhs;
  logic        bcd_in_ok;
  logic        bcd_out_ok;

  always_comb begin
    ref_add     = {1'b0, a_i} + {1'b0, m_i} + {{DW{1'b0}}, cin_i};
    ref_sub_rhs = {1'b0, m_i} + {{DW{1'b0}}, ~cin_i};
    bcd_in_ok   = 1'b1;
    bcd_out_ok  = 1'b1;
    for (int k = 0; k < NIB; k++) begin
      if (a_i[4*k +: 4] > 4'd9 || m_i[4*k +: 4] > 4'd9) bcd_in_ok = 1'b0;
      if (sum_o[4*k +: 4] > 4'd9) bcd_out_ok = 1'b0;
    end
    if (!dec_i && !sub_i) begin
      AST_BIN_ADD_SUM: assert ({c_o, sum_o} == ref_add); // R1
    end
    if (!dec_i && sub_i) begin
      AST_BIN_SUB_BORROW: assert (c_o == ({1'b0, a_i} >= ref_sub_rhs)); // R2
    end
    if (dec_i && !sub_i && bcd_in_ok) begin
      AST_BCD_ADD_DIGITS: assert (bcd_out_ok); // R3
    end
  end
endmodule

// File: rtl/acc_alu_bitwise.sv
module acc_alu_bitwise
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  bw_fn_e        fn_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      BW_OR:   res_o = a_i | m_i;
      BW_XOR:  res_o = a_i ^ m_i;
      default: res_o = a_i & m_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  input  logic          right_i,
  input  logic          rotate_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  logic fill;

  assign fill = rotate_i & cin_i;

  always_comb begin
    if (right_i) begin
      res_o  = {fill, a_i[DW-1:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[DW-2:0], fill};
      cout_o = a_i[DW-1];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic [DW-1:0]   reg_a,
  input  logic [DW-1:0]   opnd_m,
  input  logic            carry_in,
  input  logic            dec_mode,
  output logic [DW-1:0]   result,
  output logic            flag_n,
  output logic            flag_v,
  output logic            flag_z,
  output logic            flag_c,
  output logic            we_n,
  output logic            we_v,
  output logic            we_z,
  output logic            we_c
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // adder controls: compare is a binary subtract with carry forced high
  logic as_sub, as_dec, as_cin;
  logic [DW-1:0] as_sum;
  logic as_c, as_v, as_n, as_z;

  assign as_sub = (op == OP_SUB) || (op == OP_CMP);
  assign as_dec = dec_mode && ((op == OP_ADD) || (op == OP_SUB));
  assign as_cin = (op == OP_CMP) ? 1'b1 : carry_in;

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a_i   (reg_a),
    .m_i   (opnd_m),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .dec_i (as_dec),
    .sum_o (as_sum),
    .c_o   (as_c),
    .v_o   (as_v),
    .n_o   (as_n),
    .z_o   (as_z)
  );

  bw_fn_e bw_fn;
  logic [DW-1:0] bw_res;

  always_comb begin
    unique case (op)
      OP_OR:   bw_fn = BW_OR;
      OP_XOR:  bw_fn = BW_XOR;
      default: bw_fn = BW_AND;
    endcase
  end

  acc_alu_bitwise #(.DW(DW)) u_bitwise (
    .a_i   (reg_a),
    .m_i   (opnd_m),
    .fn_i  (bw_fn),
    .res_o (bw_res)
  );

  logic sh_right, sh_rot, sh_c;
  logic [DW-1:0] sh_res;

  assign sh_right = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  acc_alu_shift #(.DW(DW)) u_shift (
    .a_i      (reg_a),
    .cin_i    (carry_in),
    .right_i  (sh_right),
    .rotate_i (sh_rot),
    .res_o    (sh_res),
    .cout_o   (sh_c)
  );

  logic [DW-1:0] res_nx;
  logic n_nx, v_nx, z_nx, c_nx;
  logic wn_nx, wv_nx, wz_nx, wc_nx;

  always_comb begin
    res_nx = '0;
    n_nx   = 1'b0;
    v_nx   = 1'b0;
    z_nx   = 1'b0;
    c_nx   = 1'b0;
    wn_nx  = 1'b0;
    wv_nx  = 1'b0;
    wz_nx  = 1'b0;
    wc_nx  = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_nx = as_sum;
        n_nx   = as_n;
        v_nx   = as_v;
        z_nx   = as_z;
        c_nx   = as_c;
        {wn_nx, wv_nx, wz_nx, wc_nx} = 4'b1111;
      end
      OP_CMP: begin
        res_nx = as_sum;
        n_nx   = as_n;
        z_nx   = as_z;
        c_nx   = as_c;
        {wn_nx, wz_nx, wc_nx} = 3'b111;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_nx = bw_res;
        n_nx   = bw_res[DW-1];
        z_nx   = (bw_res == '0);
        {wn_nx, wz_nx} = 2'b11;
      end
      OP_BIT: begin
        res_nx = bw_res;
        n_nx   = opnd_m[DW-1];
        v_nx   = opnd_m[DW-2];
        z_nx   = (bw_res == '0);
        {wn_nx, wv_nx, wz_nx} = 3'b111;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_nx = sh_res;
        n_nx   = sh_res[DW-1];
        z_nx   = (sh_res == '0);
        c_nx   = sh_c;
        {wn_nx, wz_nx, wc_nx} = 3'b111;
      end
      default: begin
      end
    endcase
  end

  assign result = res_nx;
  assign flag_n = n_nx;
  assign flag_v = v_nx;
  assign flag_z = z_nx;
  assign flag_c = c_nx;
  assign we_n   = wn_nx;
  assign we_v   = wv_nx;
  assign we_z   = wz_nx;
  assign we_c   = wc_nx;

  always_comb begin
    if (op == OP_CMP) begin
      AST_CMP_UNSIGNED_GE: assert (flag_c == (reg_a >= opnd_m)); // R5
    end
    if ((op == OP_AND) || (op == OP_OR) || (op == OP_XOR)) begin
      AST_LOGIC_ZERO_FLAG: assert (flag_z == (result == '0)); // R6
    end
    if (op == OP_SHL) begin
      AST_SHL_EMPTY_LSB: assert (!result[0] && (flag_c == reg_a[DW-1])); // R8
    end
    if (op == OP_ROR) begin
      AST_ROR_CARRY_MSB: assert ((result[DW-1] == carry_in) && (flag_c == reg_a[0])); // R9
    end
    AST_IDLE_FLAG_LOW: assert ((we_v || !flag_v) && (we_c || !flag_c)); // R10
  end
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic clk;
  logic rst_n;

  logic [3:0] op_sel;
  logic [7:0] reg_a;
  logic [7:0] opnd_m;
  logic       carry_in;
  logic       dec_mode;
  logic [7:0] result;
  logic flag_n, flag_v, flag_z, flag_c;
  logic we_n, we_v, we_z, we_c;

  acc_alu dut_i (
    .op_sel   (op_sel),
    .reg_a    (reg_a),
    .opnd_m   (opnd_m),
    .carry_in (carry_in),
    .dec_mode (dec_mode),
    .result   (result),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .we_n     (we_n),
    .we_v     (we_v),
    .we_z     (we_z),
    .we_c     (we_c)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // expected {result, N, V, Z, C, weN, weV, weZ, weC}
  function automatic logic [15:0] model(input int op, input int a, input int m,
                                        input int c, input int d);
    int r, mv, s, x;
    logic n, v, z, cy, wn, wv, wz, wc;
    r = 0; n = 0; v = 0; z = 0; cy = 0; wn = 0; wv = 0; wz = 0; wc = 0;
    case (op)
      0, 1: begin
        mv = (op == 1) ? (~m & 255) : m;
        if (op == 1 && d != 0) mv = (mv - 'h66) & 255;
        s = a + mv + c;
        n = s[7];
        z = ((s & 255) == 0);
        v = (((s ^ a) & (s ^ mv) & 128) != 0);
        if (d != 0) begin
          x = (s + 'h66) ^ a ^ mv;
          s = s + ((x >> 3) & 'h22) * 3;
        end
        cy = (s > 255);
        r = s & 255;
        {wn, wv, wz, wc} = 4'b1111;
      end
      2: begin
        r = (a - m) & 255;
        n = r[7]; z = (r == 0); cy = (a >= m);
        {wn, wz, wc} = 3'b111;
      end
      3, 4, 5, 6: begin
        if (op == 4) r = a | m;
        else if (op == 5) r = a ^ m;
        else r = a & m;
        z = (r == 0);
        if (op == 6) begin
          n = m[7]; v = m[6]; {wn, wv, wz} = 3'b111;
        end else begin
          n = r[7]; {wn, wz} = 2'b11;
        end
      end
      7, 8, 9, 10: begin
        if (op == 7 || op == 9) begin
          r = ((a << 1) & 255) | ((op == 9) ? c : 0);
          cy = a[7];
        end else begin
          r = (a >> 1) | ((op == 10) ? (c << 7) : 0);
          cy = a[0];
        end
        n = r[7]; z = (r == 0);
        {wn, wz, wc} = 3'b111;
      end
      default: ;
    endcase
    return {r[7:0], n, v, z, cy, wn, wv, wz, wc};
  endfunction

  function automatic string tag_of(input int op, input int d);
    case (op)
      0:  return (d != 0) ? "R3" : "R1";
      1:  return (d != 0) ? "R4" : "R2";
      2:  return (d != 0) ? "R5/R11" : "R5";
      3, 4, 5: return (d != 0) ? "R6/R11" : "R6";
      6:  return (d != 0) ? "R7/R11" : "R7";
      7, 8: return "R8";
      9, 10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input int op, input int a, input int m, input int c,
                       input int d, input string tag);
    sb_item_t it;
    @(posedge clk);
    op_sel   = op[3:0];
    reg_a    = a[7:0];
    opnd_m   = m[7:0];
    carry_in = c[0];
    dec_mode = d[0];
    it.exp = model(op, a, m, c, d);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: outputs are combinational, due in the same period; sample at falling edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      sb_item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = {result, flag_n, flag_v, flag_z, flag_c, we_n, we_v, we_z, we_c};
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s op=%0d a=%02h m=%02h c=%0b d=%0b actual=%04h expected=%04h",
                 it.tag, op_sel, reg_a, opnd_m, carry_in, dec_mode, act, it.exp);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    op_sel = 4'd0; reg_a = 8'd0; opnd_m = 8'd0; carry_in = 1'b0; dec_mode = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state vector: all inputs zero is a binary add of zeros
    drive(0, 0, 0, 0, 0, "R1 reset");
    // directed decimal corners
    drive(0, 'h58, 'h46, 1, 1, "R3 58+46+1");
    drive(0, 'h99, 'h01, 0, 1, "R3 99+01");
    drive(0, 'h99, 'h99, 1, 1, "R3 99+99+1");
    drive(0, 'h09, 'h01, 0, 1, "R3 nibble carry");
    drive(1, 'h00, 'h01, 1, 1, "R4 00-01");
    drive(1, 'h46, 'h12, 1, 1, "R4 46-12");
    drive(1, 'h40, 'h13, 1, 1, "R4 40-13");
    drive(1, 'h32, 'h02, 0, 1, "R4 borrow in");
    drive(0, 'h7F, 'h01, 0, 0, "R1 signed overflow");
    drive(1, 'h80, 'h01, 1, 0, "R2 signed overflow");
    drive(2, 'h10, 'h10, 0, 0, "R5 equal");
    drive(6, 'h0F, 'hC0, 0, 0, "R7 zero with N V");
    drive(15, 'hFF, 'hFF, 1, 1, "R10 unused code");
    // sweep: every A, eight operands, both carries, both modes, all codes
    for (int op = 0; op < 16; op++) begin
      for (int mi = 0; mi < 8; mi++) begin
        for (int d = 0; d < 2; d++) begin
          for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 256; a++) begin
              drive(op, a, (mi * 'h25 + mi * mi * 3 + 'h0B) & 255, c, d, tag_of(op, d));
            end
          end
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 180000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule